// File: doc/BRIEF.md
# Process-Tagged Associative Translation Cache

This block caches page-to-frame mappings for a processor's memory unit. A 24-bit virtual address is split into an 11-bit page number (bits 23..13) and a 13-bit byte offset (bits 12..0), so pages are 8 KB. All entries are compared against the page number in parallel. A matching valid entry supplies a 19-bit frame number, and the 32-bit physical address is that frame number in bits 31..13 with the offset passed through unchanged in bits 12..0. The result is registered, so a response appears one cycle after its request.

Each entry stores a page number, a frame number, a process-id tag and four flags: valid, writable, referenced and dirty. With tag checking enabled, a hit also needs the stored tag to equal the current process id. A miss tells an external walker or software to fetch the mapping. That agent then writes it through the refill port, which places the new entry in the lowest-numbered invalid slot, or else in the slot named by a round-robin pointer. On a context switch, software can flush every entry, clear only the valid bits, or leave the entries in place and rely on the tags.

Top module: `vtlb`

## Requirements
- R1: On a hit, `rsp_paddr` is the entry's frame number in bits 31..13 followed by the request's address bits 12..0. The page number is request bits 23..13.
- R2: `rsp_valid` is the value `req_valid` had one cycle earlier. When `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. When it is 0, all three are 0.
- R3: A request that matches no valid entry gives `rsp_miss`=1 and `rsp_paddr`=0. If several entries match, the lowest-numbered one is used.
- R4: With `tag_en`=1, an entry matches only when its stored process id equals `cur_pid`. A refill stores `cur_pid` as the new entry's tag.
- R5: A write (`req_write`=1) that matches an entry whose writable flag is 0 gives `rsp_fault`=1 and `rsp_paddr`=0. The entry's referenced and dirty flags are left unchanged.
- R6: `rsp_ref` and `rsp_dirty` show the matched entry's flags as they were before the access. A hit sets the referenced flag, and a write hit also sets the dirty flag. A refill clears both flags.
- R7: A refill writes the lowest-numbered invalid entry if there is one, and otherwise the entry at the round-robin pointer. The pointer starts at 0 and advances by one on every refill, wrapping from ENTRIES-1 back to 0.
- R8: `flush_all` invalidates every entry and returns the round-robin pointer to 0.
- R9: `inval_all` clears every valid flag and leaves the pointer unchanged. A refill in the same cycle as `flush_all` or `inval_all` is dropped. A lookup in that same cycle still sees the old contents.
- R10: With `tag_en`=0, the stored process id is ignored when matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | 1 = write access |
| cur_pid | input | 8 | Current process id |
| tag_en | input | 1 | Require process-id match |
| fill_en | input | 1 | Write one entry |
| fill_vpn | input | 11 | Page number for refill |
| fill_pfn | input | 19 | Frame number for refill |
| fill_writable | input | 1 | Writable flag for refill |
| flush_all | input | 1 | Invalidate all and reset pointer |
| inval_all | input | 1 | Clear all valid flags |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Write to non-writable page |
| rsp_paddr | output | 32 | Physical address |
| rsp_ref | output | 1 | Matched entry's prior referenced flag |
| rsp_dirty | output | 1 | Matched entry's prior dirty flag |

## Verification
The hardest case to reach is a full table, where the refill slot comes from the round-robin pointer rather than from a free entry. The pointer's position then depends on every earlier refill, and on whether a flush or only a valid-clear came in between. The directed part fills all 64 entries, refills once more and checks which page disappeared, then repeats the check after a flush and after a valid-clear. The random part draws page numbers from a small pool so that duplicates, full-table evictions and tag mismatches recur often.

// File: rtl/vtlb.sv
module vtlb #(
  parameter int ENTRIES = 64,
  parameter int PIDW    = 8,
  parameter int VAW     = 24,
  parameter int PAW     = 32,
  parameter int OFFW    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VAW-1:0]      req_vaddr,
  input  logic                req_write,
  input  logic [PIDW-1:0]     cur_pid,
  input  logic                tag_en,
  input  logic                fill_en,
  input  logic [VAW-OFFW-1:0] fill_vpn,
  input  logic [PAW-OFFW-1:0] fill_pfn,
  input  logic                fill_writable,
  input  logic                flush_all,
  input  logic                inval_all,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_fault,
  output logic [PAW-1:0]      rsp_paddr,
  output logic                rsp_ref,
  output logic                rsp_dirty
);
  localparam int VPNW = VAW - OFFW;
  localparam int PFNW = PAW - OFFW;
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPNW-1:0] e_vpn [ENTRIES];
  logic [PFNW-1:0] e_pfn [ENTRIES];
  logic [PIDW-1:0] e_pid [ENTRIES];
  logic [ENTRIES-1:0] e_v, e_w, e_r, e_d;
  logic [IDXW-1:0] rr;

  logic [VPNW-1:0] req_vpn;
  logic            hit_any, free_any;
  logic [IDXW-1:0] hit_idx, free_idx, victim;

  assign req_vpn = req_vaddr[VAW-1:OFFW];

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_v[i] && e_vpn[i] == req_vpn && (!tag_en || e_pid[i] == cur_pid)) begin
        hit_any = 1'b1;
        hit_idx = IDXW'(i);
      end
      if (!e_v[i]) begin
        free_any = 1'b1;
        free_idx = IDXW'(i);
      end
    end
  end

  assign victim = free_any ? free_idx : rr;

  wire fault_c = hit_any && req_write && !e_w[hit_idx];
  wire good_c  = req_valid && hit_any && !fault_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_ref   <= 1'b0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= good_c;
      rsp_miss  <= req_valid && !hit_any;
      rsp_fault <= req_valid && fault_c;
      rsp_paddr <= good_c ? {e_pfn[hit_idx], req_vaddr[OFFW-1:0]} : '0;
      rsp_ref   <= req_valid && hit_any && e_r[hit_idx];
      rsp_dirty <= req_valid && hit_any && e_d[hit_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_all) begin
      e_v <= '0;
      e_w <= '0;
      e_r <= '0;
      e_d <= '0;
      rr  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0;
        e_pfn[i] <= '0;
        e_pid[i] <= '0;
      end
    end else if (inval_all) begin
      e_v <= '0;
    end else begin
      if (good_c) begin
        e_r[hit_idx] <= 1'b1;
        if (req_write) e_d[hit_idx] <= 1'b1;
      end
      if (fill_en) begin
        e_v[victim]   <= 1'b1;
        e_w[victim]   <= fill_writable;
        e_r[victim]   <= 1'b0;
        e_d[victim]   <= 1'b0;
        e_vpn[victim] <= fill_vpn;
        e_pfn[victim] <= fill_pfn;
        e_pid[victim] <= cur_pid;
        rr <= (rr == IDXW'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end
endmodule

module vtlb_chk #(
  parameter int VAW  = 24,
  parameter int PAW  = 32,
  parameter int OFFW = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [VAW-1:0] req_vaddr,
  input logic           req_write,
  input logic           flush_all,
  input logic           rsp_valid,
  input logic           rsp_hit,
  input logic           rsp_miss,
  input logic           rsp_fault,
  input logic [PAW-1:0] rsp_paddr
);
  p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> {rsp_hit, rsp_miss, rsp_fault} == 3'b000);
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_valid));
  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFFW-1:0] == $past(req_vaddr[OFFW-1:0]));
  p_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault) |-> rsp_paddr == '0);
  p_fault_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> $past(req_write));
  p_flush_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(flush_all)) |=> rsp_miss);
endmodule

bind vtlb vtlb_chk #(.VAW(VAW), .PAW(PAW), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_write(req_write), .flush_all(flush_all), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr));

// File: tb/vtlb_bench.sv
`timescale 1ns/1ps
module vtlb_bench;
  localparam int N = 64;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, tag_en = 0, fill_en = 0, fill_writable = 0;
  logic flush_all = 0, inval_all = 0;
  logic [23:0] req_vaddr = '0;
  logic [7:0]  cur_pid = '0;
  logic [10:0] fill_vpn = '0;
  logic [18:0] fill_pfn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_dirty;
  logic [31:0] rsp_paddr;

  vtlb u_vtlb (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [10:0] m_vpn [N];
  logic [18:0] m_pfn [N];
  logic [7:0]  m_pid [N];
  bit m_v [N], m_w [N], m_r [N], m_d [N];
  int m_rr = 0;

  logic e_valid, e_hit, e_miss, e_fault, e_ref, e_dirty;
  logic [31:0] e_paddr;

  function automatic int m_find(logic [10:0] vpn, logic [7:0] pid, bit ten);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (!ten || m_pid[i] == pid)) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return m_rr;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_r[i] = 0; m_d[i] = 0;
      m_vpn[i] = '0; m_pfn[i] = '0; m_pid[i] = '0;
    end
    m_rr = 0;
  endfunction

  task automatic cyc(string tag, bit rv, logic [23:0] va, bit wr, logic [7:0] pid, bit ten,
                     bit fe, logic [10:0] fv, logic [18:0] fp, bit fw, bit fl, bit iv);
    int h, vic;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_write = wr; cur_pid = pid; tag_en = ten;
    fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_writable = fw;
    flush_all = fl; inval_all = iv;
    h = m_find(va[23:13], pid, ten);
    e_valid = rv;
    e_hit = rv && h >= 0 && !(wr && !m_w[h >= 0 ? h : 0]);
    e_fault = rv && h >= 0 && wr && !m_w[h >= 0 ? h : 0];
    e_miss = rv && h < 0;
    e_paddr = e_hit ? {m_pfn[h], va[12:0]} : 32'h0;
    e_ref = rv && h >= 0 && m_r[h >= 0 ? h : 0];
    e_dirty = rv && h >= 0 && m_d[h >= 0 ? h : 0];
    vic = m_victim();
    if (fl) m_clear();
    else if (iv) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      if (e_hit) begin
        m_r[h] = 1;
        if (wr) m_d[h] = 1;
      end
      if (fe) begin
        m_v[vic] = 1; m_w[vic] = fw; m_r[vic] = 0; m_d[vic] = 0;
        m_vpn[vic] = fv; m_pfn[vic] = fp; m_pid[vic] = pid;
        m_rr = (m_rr + 1) % N;
      end
    end
    @(posedge clk); #1;
    checks++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault} !== {e_valid, e_hit, e_miss, e_fault}) begin
      fails++;
      $display("FAIL %s flags v/h/m/f got %b exp %b", tag,
               {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, {e_valid, e_hit, e_miss, e_fault});
    end
    checks++;
    if (rsp_paddr !== e_paddr) begin
      fails++;
      $display("FAIL %s R1 paddr got %h exp %h", tag, rsp_paddr, e_paddr);
    end
    checks++;
    if ({rsp_ref, rsp_dirty} !== {e_ref, e_dirty}) begin
      fails++;
      $display("FAIL %s R6 ref/dirty got %b exp %b", tag, {rsp_ref, rsp_dirty}, {e_ref, e_dirty});
    end
  endtask

  task automatic look(string tag, logic [10:0] vpn, logic [12:0] off, bit wr, logic [7:0] pid, bit ten);
    cyc(tag, 1, {vpn, off}, wr, pid, ten, 0, '0, '0, 0, 0, 0);
  endtask

  task automatic fill(string tag, logic [10:0] vpn, logic [18:0] pfn, bit w, logic [7:0] pid);
    cyc(tag, 0, '0, 0, pid, 1, 1, vpn, pfn, w, 0, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault} !== 4'b0) begin
      fails++;
      $display("FAIL R2 reset flags got %b exp 0000", {rsp_valid, rsp_hit, rsp_miss, rsp_fault});
    end
    @(negedge clk); rst_n = 1;

    look("R3 empty", 11'd5, 13'h123, 0, 8'd0, 1);
    fill("R7 first", 11'd5, 19'h4_1234, 1, 8'd1);
    look("R1 hit", 11'd5, 13'h1abc, 0, 8'd1, 1);
    look("R6 ref set", 11'd5, 13'h0001, 1, 8'd1, 1);
    look("R6 dirty set", 11'd5, 13'h1fff, 0, 8'd1, 1);
    look("R4 pid mismatch", 11'd5, 13'h0, 0, 8'd2, 1);
    look("R10 tag off", 11'd5, 13'h7, 0, 8'd2, 0);
    fill("R5 ro", 11'd2047, 19'h7_ffff, 0, 8'd1);
    look("R5 fault", 11'd2047, 13'h10, 1, 8'd1, 1);
    look("R5 no update", 11'd2047, 13'h11, 0, 8'd1, 1);
    look("R5 read ok", 11'd2047, 13'h12, 0, 8'd1, 1);
    cyc("R9 same cycle", 1, {11'd5, 13'h2}, 0, 8'd1, 1, 1, 11'd9, 19'h9, 1, 0, 1);
    look("R9 inval", 11'd5, 13'h2, 0, 8'd1, 1);
    look("R9 fill dropped", 11'd9, 13'h2, 0, 8'd1, 1);
    for (int i = 0; i < N; i++) fill("R7 fill", 11'(100 + i), 19'(i + 1), 1, 8'd3);
    fill("R7 evict", 11'd900, 19'h1_2345, 1, 8'd3);
    for (int i = 0; i < 4; i++) look("R7 after evict", 11'(100 + i), 13'h5, 0, 8'd3, 1);
    look("R7 newest", 11'd900, 13'h5, 0, 8'd3, 1);
    cyc("R8 flush", 1, {11'd101, 13'h0}, 0, 8'd3, 1, 1, 11'd7, 19'h7, 1, 1, 0);
    look("R8 after flush", 11'd101, 13'h0, 0, 8'd3, 1);
    for (int i = 0; i < N + 3; i++) fill("R8 refill", 11'(200 + i), 19'(i + 50), 1, 8'd3);
    for (int i = 0; i < 5; i++) look("R8 pointer", 11'(200 + i), 13'h9, 0, 8'd3, 1);
    cyc("R9 inval keep ptr", 0, '0, 0, 8'd3, 1, 0, '0, '0, 0, 0, 1);
    for (int i = 0; i < N + 2; i++) fill("R9 refill", 11'(300 + i), 19'(i + 7), 1, 8'd3);
    for (int i = 0; i < 6; i++) look("R9 pointer", 11'(300 + i), 13'h3, 0, 8'd3, 1);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      logic [10:0] v = 11'($urandom_range(0, 23));
      logic [10:0] fv = 11'($urandom_range(0, 23));
      if ($urandom_range(0, 9) == 0) v = 11'd2047 - v;
      cyc("R1/R3/R4/R5/R6/R7 random", $urandom_range(0, 9) < 7, {v, 13'($urandom)},
          $urandom_range(0, 2) == 0, 8'($urandom_range(0, 3)), $urandom_range(0, 4) != 0,
          $urandom_range(0, 3) == 0, fv, 19'($urandom), $urandom_range(0, 3) != 0,
          $urandom_range(0, 199) == 0, $urandom_range(0, 149) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule